// File: doc/BRIEF.md
# Tiled Display-List Pointer Allocator

This block appends object references to per-tile display lists kept in memory. Five list kinds are served: opaque polygons, opaque modifiers, translucent polygons, translucent modifiers and punch-through polygons. Each kind has its own size code, which either disables the kind or picks a block of 8, 16 or 32 words. A block holds one fewer object pointer than it has words. Its final word is a link to the next block.

Upstream logic offers one append at a time over a valid/ready handshake. The append names a tile, a list kind and a 32-bit object reference. The block keeps a write pointer for each pair of tile and kind, and turns each append into one or two registered memory writes. When a block is full, the next block is carved from a pool that starts at a programmed address and grows toward lower addresses. The carving stops at a programmed lower bound. An init pulse rewinds the pool and forgets every list.

Top module: `tile_list_alloc`

## Requirements
- R1: After reset, `in_ready` is 1, `overflow` and `list_error` are 0, `wr_valid` is 0 and `pool_pos` equals `pool_start`.
- R2: List kind k (0 opaque polygons, 1 opaque modifiers, 2 translucent polygons, 3 translucent modifiers, 4 punch-through) takes its size code from `size_cfg[2k+1:2k]`. Code 1 gives an 8-word block, code 2 a 16-word block and code 3 a 32-word block. A word is 4 bytes and all addresses are byte addresses.
- R3: The first append to a pair of tile and kind allocates a block and writes the object at the block base. The write appears one cycle after acceptance.
- R4: Later appends to the same pair write to consecutive word addresses going up through the block, one write per append.
- R5: An append that finds its block holding N-1 objects takes two cycles. First, a link write goes to the block's last word, carrying the new block base as data. In the next cycle, the object write goes to the new base. `in_ready` is 0 during that second cycle.
- R6: Each allocation lowers `pool_pos` by the block size in bytes, and the new block base is the new `pool_pos`.
- R7: If `pool_pos` minus the block size would fall below `pool_end`, no write occurs, `pool_pos` is unchanged and `overflow` becomes 1 and stays 1.
- R8: While `overflow` is 1, appends to enabled kinds are accepted and produce no write.
- R9: An append to a kind whose code is 0, or with a kind index of 5 to 7, produces no write and sets the sticky `list_error`.
- R10: An `init` pulse holds `in_ready` at 0 and sets `pool_pos` to `pool_start`. It clears both flags and empties every list, so the next append to any pair allocates a fresh block.
- R11: Lists for different tiles and different kinds advance independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init | input | 1 | Rewind pool and empty all lists |
| size_cfg | input | 10 | Five 2-bit block-size codes |
| pool_start | input | ADDR_W | Top of pool (first block ends here) |
| pool_end | input | ADDR_W | Lowest address the pool may use |
| in_valid | input | 1 | Append offered |
| in_ready | output | 1 | Append can be taken this cycle |
| in_tile | input | TILE_W | Tile number |
| in_list | input | 3 | List kind |
| in_obj | input | DATA_W | Object reference to store |
| wr_valid | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | DATA_W | Write data |
| pool_pos | output | ADDR_W | Next allocation position |
| overflow | output | 1 | Sticky pool exhaustion |
| list_error | output | 1 | Sticky append to disabled kind |

## Verification
The bench builds the block with NUM_TILES=4, ADDR_W=16 and DATA_W=32. With these values the table has 20 entries, so a few hundred random appends revisit each pair often enough to fill 8-, 16- and 32-word blocks and force link writes. The 16-bit address space lets a pool of only 64 bytes be set up, which drives both the case where the pool has room and the exhaustion edge, followed by recovery through init.

// File: rtl/tile_list_alloc.sv
module tile_list_alloc #(
  parameter int NUM_TILES = 16,
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic [9:0]           size_cfg,
  input  logic [ADDR_W-1:0]    pool_start,
  input  logic [ADDR_W-1:0]    pool_end,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [$clog2(NUM_TILES)-1:0] in_tile,
  input  logic [2:0]           in_list,
  input  logic [DATA_W-1:0]    in_obj,
  output logic                 wr_valid,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic [ADDR_W-1:0]    pool_pos,
  output logic                 overflow,
  output logic                 list_error
);
  localparam int NUM_LISTS = 5;
  localparam int ENTRIES   = NUM_TILES * NUM_LISTS;
  localparam int IDX_W     = $clog2(ENTRIES);

  logic [ADDR_W-1:0] ptr_q  [ENTRIES];
  logic [4:0]        slot_q [ENTRIES];
  logic [ENTRIES-1:0] live_q;
  logic              busy_q;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_obj;

  logic [15:0]       cfg_pad;
  logic [1:0]        code;
  logic              list_ok;
  logic [IDX_W-1:0]  sel;
  logic [ADDR_W:0]   blk_bytes;
  logic [4:0]        last_slot;
  logic              need_alloc;
  logic              fits;
  logic [ADDR_W-1:0] new_base;
  logic              accept;

  assign cfg_pad    = {6'b0, size_cfg};
  assign code       = cfg_pad[{in_list, 1'b0} +: 2];
  assign list_ok    = code != 2'd0;
  assign sel        = list_ok ? IDX_W'(IDX_W'(in_tile) * IDX_W'(NUM_LISTS) + IDX_W'(in_list)) : '0;
  assign blk_bytes  = (ADDR_W+1)'(16) << code;
  assign last_slot  = (5'd4 << code) - 5'd1;
  assign need_alloc = !live_q[sel] || (slot_q[sel] == last_slot);
  assign fits       = {1'b0, pool_pos} >= ({1'b0, pool_end} + blk_bytes);
  assign new_base   = pool_pos - blk_bytes[ADDR_W-1:0];
  assign in_ready   = !busy_q && !init;
  assign accept     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pool_pos   <= pool_start;
      live_q     <= '0;
      overflow   <= 1'b0;
      list_error <= 1'b0;
      busy_q     <= 1'b0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      hold_addr  <= '0;
      hold_obj   <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (init) begin
        pool_pos   <= pool_start;
        live_q     <= '0;
        overflow   <= 1'b0;
        list_error <= 1'b0;
        busy_q     <= 1'b0;
      end else if (busy_q) begin
        wr_valid <= 1'b1;
        wr_addr  <= hold_addr;
        wr_data  <= hold_obj;
        busy_q   <= 1'b0;
      end else if (accept) begin
        if (!list_ok) begin
          list_error <= 1'b1;
        end else if (!overflow) begin
          if (!need_alloc) begin
            wr_valid     <= 1'b1;
            wr_addr      <= ptr_q[sel];
            wr_data      <= in_obj;
            ptr_q[sel]   <= ptr_q[sel] + ADDR_W'(4);
            slot_q[sel]  <= slot_q[sel] + 5'd1;
          end else if (!fits) begin
            overflow <= 1'b1;
          end else begin
            pool_pos    <= new_base;
            ptr_q[sel]  <= new_base + ADDR_W'(4);
            slot_q[sel] <= 5'd1;
            live_q[sel] <= 1'b1;
            wr_valid    <= 1'b1;
            if (live_q[sel]) begin
              wr_addr   <= ptr_q[sel];
              wr_data   <= DATA_W'(new_base);
              busy_q    <= 1'b1;
              hold_addr <= new_base;
              hold_obj  <= in_obj;
            end else begin
              wr_addr <= new_base;
              wr_data <= in_obj;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/tile_list_alloc_chk.sv
module tile_list_alloc_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] pool_pos,
  input logic              overflow,
  input logic              list_error
);
  AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[1:0] == 2'b00); // R4

  AST_POOL_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(init) && pool_pos != $past(pool_pos)) |-> pool_pos < $past(pool_pos)); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(overflow) && !$past(init)) |-> overflow); // R7

  AST_NO_WRITE_AFTER_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(overflow) && overflow) |-> !wr_valid); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(list_error) && !$past(init)) |-> list_error); // R9

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (!overflow && !list_error && !wr_valid)); // R10
endmodule

bind tile_list_alloc tile_list_alloc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .pool_pos(pool_pos), .overflow(overflow), .list_error(list_error)
);

// File: tb/tile_list_alloc_tb.sv
module tile_list_alloc_tb;
  localparam int NT = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NE = NT * 5;

  logic clk = 0, rst_n = 0, init = 0, in_valid = 0;
  logic [9:0] size_cfg = 10'b01_00_11_10_01;
  logic [AW-1:0] pool_start = 16'h8000, pool_end = 16'h0000;
  logic [1:0] in_tile = 0;
  logic [2:0] in_list = 0;
  logic [DW-1:0] in_obj = 0;
  logic in_ready, wr_valid, overflow, list_error;
  logic [AW-1:0] wr_addr, pool_pos;
  logic [DW-1:0] wr_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int m_ptr [NE];
  int m_slot[NE];
  bit m_live[NE];
  int m_pos;
  bit m_ovf, m_err;

  always #2 clk = ~clk;

  tile_list_alloc #(.NUM_TILES(NT), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .init(init), .size_cfg(size_cfg),
    .pool_start(pool_start), .pool_end(pool_end), .in_valid(in_valid),
    .in_ready(in_ready), .in_tile(in_tile), .in_list(in_list), .in_obj(in_obj),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .pool_pos(pool_pos), .overflow(overflow), .list_error(list_error)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int code_of(int lst);
    if (lst > 4) return 0;
    return (int'(size_cfg) >> (2 * lst)) & 3;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NE; i++) m_live[i] = 0;
    m_pos = int'(pool_start);
    m_ovf = 0;
    m_err = 0;
  endtask

  task automatic check_flags(string req);
    chk({req, " pos"}, int'(pool_pos), m_pos);
    chk({req, " ovf"}, int'(overflow), int'(m_ovf));
    chk({req, " err"}, int'(list_error), int'(m_err));
  endtask

  task automatic append(int t, int l, int obj);
    int code, idx, bytes, nb, e_addr, e_data;
    bit wr, link;
    code = code_of(l);
    idx = t * 5 + l;
    wr = 0; link = 0; e_addr = 0; e_data = 0; nb = 0;
    if (code == 0) m_err = 1;
    else if (!m_ovf) begin
      bytes = 16 << code;
      if (m_live[idx] && m_slot[idx] != (8 << (code - 1)) - 1) begin
        wr = 1; e_addr = m_ptr[idx]; e_data = obj;
        m_ptr[idx] += 4; m_slot[idx]++;
      end else if (m_pos < int'(pool_end) + bytes) begin
        m_ovf = 1;
      end else begin
        nb = m_pos - bytes;
        wr = 1;
        if (m_live[idx]) begin link = 1; e_addr = m_ptr[idx]; e_data = nb; end
        else begin e_addr = nb; e_data = obj; end
        m_pos = nb; m_ptr[idx] = nb + 4; m_slot[idx] = 1; m_live[idx] = 1;
      end
    end
    @(negedge clk);
    in_valid = 1; in_tile = 2'(t); in_list = 3'(l); in_obj = obj;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    if (code == 0) chk("R9 no write", int'(wr_valid), 0);
    else if (!wr) chk("R7/R8 no write", int'(wr_valid), 0);
    else begin
      chk("R3/R4 wr_valid", int'(wr_valid), 1);
      chk(link ? "R5 link addr" : "R3/R4 addr", int'(wr_addr), e_addr);
      chk(link ? "R5 link data" : "R3/R4 data", int'(wr_data), e_data);
    end
    check_flags("R6/R11");
    if (link) begin
      chk("R5 ready low", int'(in_ready), 0);
      @(negedge clk);
      chk("R5 obj valid", int'(wr_valid), 1);
      chk("R5 obj addr", int'(wr_addr), nb);
      chk("R5 obj data", int'(wr_data), obj);
    end
  endtask

  task automatic do_init();
    @(negedge clk);
    init = 1;
    #0 chk("R10 ready during init", int'(in_ready), 0);
    @(negedge clk);
    init = 0;
    model_clear();
    check_flags("R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_clear();
    @(negedge clk);
    chk("R1 ready", int'(in_ready), 1);
    chk("R1 wr_valid", int'(wr_valid), 0);
    check_flags("R1");

    // R2/R3/R4/R5: 8-word blocks on kind 0, tile 0
    for (int i = 0; i < 9; i++) append(0, 0, 32'hA000 + i);
    // R11: another tile and kind, 16- and 32-word blocks
    append(1, 1, 32'hB001);
    append(2, 2, 32'hC001);
    append(0, 0, 32'hA009);
    // R9: disabled kind 3 and out-of-range kind 6
    append(3, 3, 32'hDEAD);
    append(3, 6, 32'hBEEF);
    append(1, 4, 32'hE001);

    // random mix
    for (int i = 0; i < 400; i++)
      append(int'($urandom_range(0, 3)), int'($urandom_range(0, 5)), int'($urandom));

    // R7/R8/R10: small pool
    pool_end = 16'h8000 - 16'h40;
    do_init();
    append(1, 0, 32'h111);   // 32 bytes, fits
    append(1, 2, 32'h222);   // 128 bytes, fails
    chk("R7 overflow set", int'(overflow), 1);
    append(2, 0, 32'h333);   // dropped
    append(1, 0, 32'h444);   // dropped
    do_init();
    append(1, 0, 32'h555);   // fresh block at start-32
    chk("R10 fresh base", int'(pool_pos), 32'h8000 - 32);
    for (int i = 0; i < 8; i++) append(1, 0, 32'h600 + i);
    append(0, 0, 32'h700);   // pool exhausted now
    chk("R7 exhausted", int'(overflow), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule